// File: doc/BRIEF.md
# Multi-Domain Write Merger

This block lets several producers, each running on its own unrelated clock, store words into one shared single-port memory that runs on a separate memory clock. Every producer has a write port with address, data, valid and ready. Each port feeds a shallow dual-clock FIFO. The FIFO holds the address and the data together in one entry, so a write stays whole as it crosses into the memory domain.

In the memory domain a round-robin arbiter chooses one non-empty FIFO per cycle and drains one entry from it. That entry is written into the internal memory model. When a FIFO fills, the ready signal of its producer drops, so each producer is stalled separately instead of being absorbed by deep buffering.

The commit port reports each write one memory cycle after its grant. It gives the source index, the address, and the word read back from the memory at that address. Each domain has its own reset, which is synchronized inside the block.

Top module: `xdw_merge`

## Requirements
- R1: Each source's `src_ready` goes low once its FIFO holds `DEPTH` unread entries. While the memory domain is held in reset, a source that keeps `src_valid` high completes exactly `DEPTH` handshakes and then sees `src_ready` low.
- R2: Every accepted write of a source is committed exactly once and in acceptance order. `wr_addr` equals the accepted address, and `wr_data` equals the accepted data as read back from the internal memory at that address.
- R3: At most one write is committed per memory clock cycle. A commit appears on `wr_fire`/`wr_src`/`wr_addr`/`wr_data` in the memory cycle after the arbiter grants an entry, and `wr_fire` is low in a cycle that follows a cycle with no grant.
- R4: Arbitration is round-robin. After source i is granted, the next grant goes to the first non-empty source in the order i+1, i+2, … (modulo `NUM_SRC`). After memory-domain reset, the search starts at source 0.
- R5: A grant is given only to a source whose FIFO is non-empty. `wr_src` is the binary index (0 to `NUM_SRC`-1) of the committing source.
- R6: While `mem_rst_n` is low, `wr_fire` is 0. While a source's `src_rst_n[i]` is low, its `src_ready[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | NUM_SRC | One clock per source |
| src_rst_n | input | NUM_SRC | Active-low asynchronous reset per source, synchronized inside |
| src_valid | input | NUM_SRC | Source i offers a write |
| src_ready | output | NUM_SRC | Source i's FIFO can take a write |
| src_addr | input | NUM_SRC*AW | Write addresses, source i in bits [i*AW +: AW] |
| src_data | input | NUM_SRC*DW | Write data, source i in bits [i*DW +: DW] |
| mem_clk | input | 1 | Memory domain clock |
| mem_rst_n | input | 1 | Active-low asynchronous memory-domain reset, synchronized inside |
| wr_fire | output | 1 | A write was committed this cycle |
| wr_src | output | $clog2(NUM_SRC) | Index of the committing source |
| wr_addr | output | AW | Committed address |
| wr_data | output | DW | Word read back from memory at `wr_addr` |

## Verification
The arbitration order is hard to see from the ports. Once producers run at their own rates, the FIFOs are rarely all non-empty at the same moment. To create that condition, the bench holds the memory domain in reset while every producer streams writes. All FIFOs therefore fill to `DEPTH`, which also exercises the stall. Releasing the memory reset then makes every FIFO become non-empty in the same cycle, so the first `NUM_SRC*DEPTH` commits must rotate strictly through sources 0, 1, 2, 3. After that, irregular gaps per source exercise ordering and exactly-once delivery under mixed clock ratios.

// File: rtl/xdw_pkg.sv
package xdw_pkg;
   function automatic int unsigned idx_width(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic logic [31:0] to_gray(logic [31:0] b);
      return b ^ (b >> 1);
   endfunction
endpackage

// File: rtl/xdw_rst_sync.sv
module xdw_rst_sync (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n
);
   logic [1:0] stg;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg <= 2'b00;
      else         stg <= {stg[0], 1'b1};
   end
   assign rst_n = stg[1];
endmodule

// File: rtl/xdw_sync.sv
module xdw_sync #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] s1;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= '0;
         q  <= '0;
      end else begin
         s1 <= d;
         q  <= s1;
      end
   end
endmodule

// File: rtl/xdw_afifo.sv
module xdw_afifo #(
   parameter int EW    = 22,
   parameter int DEPTH = 4
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          push,
   input  logic [EW-1:0] wentry,
   output logic          ready,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          pop,
   output logic [EW-1:0] rentry,
   output logic          empty
);
   import xdw_pkg::*;
   localparam int AWID = $clog2(DEPTH);
   localparam int PW   = AWID + 1;

   logic [EW-1:0] store [DEPTH];
   logic [PW-1:0] wbin, wgray, rgray_w;
   logic [PW-1:0] rbin, rgray, wgray_r;
   logic [PW-1:0] wbin_nx, rbin_nx;
   logic          full;

   // write domain
   assign wbin_nx = wbin + PW'(1);
   assign full    = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
   assign ready   = wrst_n & ~full;

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (push && !full) begin
         wbin  <= wbin_nx;
         wgray <= PW'(to_gray(32'(wbin_nx)));
      end
   end

   always_ff @(posedge wclk) begin
      if (wrst_n && push && !full) store[wbin[AWID-1:0]] <= wentry;
   end

   xdw_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));

   // read domain
   assign rbin_nx = rbin + PW'(1);
   assign empty   = (rgray == wgray_r);
   assign rentry  = store[rbin[AWID-1:0]];

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (pop && !empty) begin
         rbin  <= rbin_nx;
         rgray <= PW'(to_gray(32'(rbin_nx)));
      end
   end

   xdw_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));
endmodule

// File: rtl/xdw_rr_arb.sv
module xdw_rr_arb #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gidx
);
   logic [IW-1:0] last;
   logic          found;

   always_comb begin
      gnt   = '0;
      gidx  = '0;
      found = 1'b0;
      for (int o = 1; o <= N; o++) begin
         int j;
         j = (int'(last) + o) % N;
         if (!found && req[j]) begin
            gnt[j] = 1'b1;
            gidx   = IW'(j);
            found  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     last <= IW'(N - 1);
      else if (found) last <= gidx;
   end
endmodule

// File: rtl/xdw_mem_model.sv
module xdw_mem_model #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] echo
);
   localparam int WORDS = 1 << AW;
   logic [DW-1:0] cells [WORDS];
   logic [AW-1:0] last_a;

   always_ff @(posedge clk) begin
      if (we) begin
         cells[addr] <= wdata;
         last_a      <= addr;
      end
   end
   assign echo = cells[last_a];
endmodule

// File: rtl/xdw_merge.sv
module xdw_merge #(
   parameter int NUM_SRC = 4,
   parameter int DEPTH   = 4,
   parameter int AW      = 6,
   parameter int DW      = 16
) (
   input  logic [NUM_SRC-1:0]         src_clk,
   input  logic [NUM_SRC-1:0]         src_rst_n,
   input  logic [NUM_SRC-1:0]         src_valid,
   output logic [NUM_SRC-1:0]         src_ready,
   input  logic [NUM_SRC*AW-1:0]      src_addr,
   input  logic [NUM_SRC*DW-1:0]      src_data,
   input  logic                       mem_clk,
   input  logic                       mem_rst_n,
   output logic                       wr_fire,
   output logic [$clog2(NUM_SRC)-1:0] wr_src,
   output logic [AW-1:0]              wr_addr,
   output logic [DW-1:0]              wr_data
);
   localparam int IW = $clog2(NUM_SRC);
   localparam int EW = AW + DW;

   if (NUM_SRC < 2) begin : g_bad_n
      $error("NUM_SRC must be at least 2");
   end
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 4");
   end

   logic               mem_rst_q;
   logic [NUM_SRC-1:0] req_vec, gnt_vec;
   logic [EW-1:0]      head [NUM_SRC];
   logic [IW-1:0]      gidx;
   logic [EW-1:0]      sel;
   logic [AW-1:0]      cm_addr;
   logic [DW-1:0]      cm_data;

   xdw_rst_sync u_mrst (.clk(mem_clk), .arst_n(mem_rst_n), .rst_n(mem_rst_q));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic srst_q;
      logic emp;
      xdw_rst_sync u_srst (.clk(src_clk[i]), .arst_n(src_rst_n[i]), .rst_n(srst_q));
      xdw_afifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
         .wclk   (src_clk[i]),
         .wrst_n (srst_q),
         .push   (src_valid[i]),
         .wentry ({src_addr[i*AW +: AW], src_data[i*DW +: DW]}),
         .ready  (src_ready[i]),
         .rclk   (mem_clk),
         .rrst_n (mem_rst_q),
         .pop    (gnt_vec[i]),
         .rentry (head[i]),
         .empty  (emp)
      );
      assign req_vec[i] = ~emp;
   end

   xdw_rr_arb #(.N(NUM_SRC), .IW(IW)) u_arb (
      .clk(mem_clk), .rst_n(mem_rst_q), .req(req_vec), .gnt(gnt_vec), .gidx(gidx)
   );

   assign sel = head[gidx];

   always_ff @(posedge mem_clk or negedge mem_rst_q) begin
      if (!mem_rst_q) begin
         wr_fire <= 1'b0;
         wr_src  <= '0;
         wr_addr <= '0;
      end else begin
         wr_fire <= |gnt_vec;
         if (|gnt_vec) begin
            wr_src  <= gidx;
            wr_addr <= sel[EW-1:DW];
         end
      end
   end

   assign cm_addr = sel[EW-1:DW];
   assign cm_data = sel[DW-1:0];

   xdw_mem_model #(.AW(AW), .DW(DW)) u_mem (
      .clk(mem_clk), .we(|gnt_vec), .addr(cm_addr), .wdata(cm_data), .echo(wr_data)
   );
endmodule

// File: rtl/xdw_merge_chk.sv
module xdw_merge_chk #(
   parameter int N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] req,
   input logic [N-1:0] gnt,
   input logic         fire
);
   assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   assert_fire_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt) |=> fire);

   assert_idle_after_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(|gnt) |=> !fire);

   for (genvar i = 0; i < N; i++) begin : g_p
      assert_grant_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
         gnt[i] |-> req[i]);

      assert_rr_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(gnt[i]) && req[(i + 1) % N]) |-> gnt[(i + 1) % N]);
   end
endmodule

bind xdw_merge xdw_merge_chk #(.N(NUM_SRC)) u_chk (
   .clk(mem_clk), .rst_n(mem_rst_q), .req(req_vec), .gnt(gnt_vec), .fire(wr_fire)
);

// File: tb/tb_xdw_merge.sv
`timescale 1ns/1ps
module tb_xdw_merge;
   localparam int N     = 4;
   localparam int DEPTH = 4;
   localparam int AW    = 6;
   localparam int DW    = 16;
   localparam int IW    = 2;
   localparam int NW    = 40;

   logic [N-1:0]    sclk = '0;
   logic [N-1:0]    srst_n = '0;
   logic [N-1:0]    svalid;
   logic [N-1:0]    sready;
   logic [N*AW-1:0] saddr;
   logic [N*DW-1:0] sdata;
   logic [N*8-1:0]  kflat;
   logic            mclk = 1'b0;
   logic            mrst_n = 1'b0;
   logic            wr_fire;
   logic [IW-1:0]   wr_src;
   logic [AW-1:0]   wr_addr;
   logic [DW-1:0]   wr_data;

   int errors = 0;
   int checks = 0;
   int nexp [N];
   int ncommit = 0;

   function automatic logic [AW-1:0] exp_addr(int s, int k);
      return AW'((s * 13 + k * 5) % 64);
   endfunction
   function automatic logic [DW-1:0] exp_data(int s, int k);
      return DW'((s * 4099 + k * 37 + 11) % 65536);
   endfunction
   function automatic int gap_of(int s, int k);
      return (k < 8) ? 0 : (s * 3 + k) % 4;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always #2 mclk = ~mclk;

   xdw_merge #(.NUM_SRC(N), .DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
      .src_clk(sclk), .src_rst_n(srst_n), .src_valid(svalid), .src_ready(sready),
      .src_addr(saddr), .src_data(sdata),
      .mem_clk(mclk), .mem_rst_n(mrst_n),
      .wr_fire(wr_fire), .wr_src(wr_src), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   for (genvar g = 0; g < N; g++) begin : g_drv
      localparam real HALF = (5.0 + 2.0 * g) / 2.0;
      logic [7:0] k;
      logic       v;
      logic [2:0] gap;

      initial forever #(HALF) sclk[g] = ~sclk[g];

      always @(posedge sclk[g] or negedge srst_n[g]) begin
         if (!srst_n[g]) begin
            k   <= '0;
            v   <= 1'b0;
            gap <= '0;
         end else if (v) begin
            if (sready[g]) begin
               k <= k + 8'd1;
               if (int'(k) + 1 < NW && gap_of(g, int'(k) + 1) == 0) v <= 1'b1;
               else begin
                  v   <= 1'b0;
                  gap <= 3'(gap_of(g, int'(k) + 1));
               end
            end
         end else if (gap != 0) begin
            gap <= gap - 3'd1;
         end else if (int'(k) < NW) begin
            v <= 1'b1;
         end
      end

      assign svalid[g]          = v;
      assign kflat[g*8 +: 8]    = k;
      assign saddr[g*AW +: AW]  = exp_addr(g, int'(k));
      assign sdata[g*DW +: DW]  = exp_data(g, int'(k));
   end

   // commit monitor, sampled between memory clock edges
   always @(negedge mclk) begin
      if (mrst_n && wr_fire) begin
         int s;
         int k;
         s = int'(wr_src);
         k = nexp[s];
         chk(k < NW, "R2 commit count per source", k, NW - 1);
         chk(wr_addr == exp_addr(s, k), "R2 address", int'(wr_addr), int'(exp_addr(s, k)));
         chk(wr_data == exp_data(s, k), "R2 data read back", int'(wr_data), int'(exp_data(s, k)));
         if (ncommit < N * DEPTH)
            chk(s == ncommit % N, "R4 rotation after simultaneous fill", s, ncommit % N);
         nexp[s] = k + 1;
         ncommit++;
      end
   end

   initial begin
      int cyc;
      bit done;
      for (int i = 0; i < N; i++) nexp[i] = 0;

      // reset state
      #41;
      for (int i = 0; i < N; i++)
         chk(sready[i] == 1'b0, "R6 ready low in source reset", int'(sready[i]), 0);
      chk(wr_fire == 1'b0, "R6 no commit in memory reset", int'(wr_fire), 0);

      // sources run while memory domain stays in reset
      srst_n = '1;
      #500.3;
      for (int i = 0; i < N; i++) begin
         chk(int'(kflat[i*8 +: 8]) == DEPTH, "R1 handshakes before stall", int'(kflat[i*8 +: 8]), DEPTH);
         chk(sready[i] == 1'b0, "R1 ready low when full", int'(sready[i]), 0);
      end
      chk(wr_fire == 1'b0, "R6 no commit while memory reset held", int'(wr_fire), 0);
      chk(ncommit == 0, "R3 no commit before memory reset release", ncommit, 0);

      @(negedge mclk);
      mrst_n = 1'b1;

      cyc  = 0;
      done = 1'b0;
      while (!done && cyc < 100000) begin
         @(negedge mclk);
         cyc++;
         done = 1'b1;
         for (int i = 0; i < N; i++) if (nexp[i] < NW) done = 1'b0;
      end
      if (!done) chk(1'b0, "R2 watchdog expired", ncommit, N * NW);

      repeat (100) @(negedge mclk);
      chk(ncommit == N * NW, "R2 total commits", ncommit, N * NW);
      for (int i = 0; i < N; i++)
         chk(nexp[i] == NW, "R2 per-source commits", nexp[i], NW);
      chk(wr_fire == 1'b0, "R3 idle when all FIFOs drained", int'(wr_fire), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule